// File: doc/BRIEF.md
# Multi-mode 16-bit timer/counter

This block is a 16-bit up/down count register that can be clocked in four ways. In timer mode it steps once per prescaled tick, where the prescaler divides the system clock by 8 shifted left by a 3-bit code. Gated mode uses the same ticks, but they only take effect while the gate input is at the chosen level, which lets software measure pulse widths and duty cycles. Event mode steps on edges of an external pin, and the edge kind can be selected. Quadrature mode follows two position-sensor phases and counts up or down with the position.

All external pins pass through two-flop synchronisers before any logic sees them. A toggle latch flips each time the count wraps, in either direction, and drives an output pin. The quadrature decoder is a four-state machine named by the phase pair: `Q00`, `Q10`, `Q11` and `Q01`. It treats an advance one place around the ring `Q00 -> Q10 -> Q11 -> Q01 -> Q00` as a forward step, and a move one place the other way as a backward step. A jump to the opposite state is illegal; the count ignores it and a sticky error flag is set. Software drives the control inputs directly as register fields and can preload the count.

Top module: `mode_timer`

## Requirements
- R1: After reset the count is 0x0000, and the toggle output, the direction output and the error flag are all 0.
- R2: When `load_en` is high at a clock edge, the count takes `load_val` at that edge. A load overrides any step in the same cycle and never flips the toggle output.
- R3: With `run` low the count holds its value. The prescaler clears while `run` is low, so after `run` rises the first tick comes exactly 8<<code cycles later.
- R4: Timer mode (`mode`=00): after N cycles of `run`, the count has moved by floor(N/(8<<presc_code)). It moves up when `dir_down`=0 and down when `dir_down`=1.
- R5: Gated mode (`mode`=01): prescaled ticks step the count only while the synchronised `pin_a` equals `gate_pol`. In any other case the count holds.
- R6: Event mode (`mode`=10): the count steps once for each edge of `pin_a` that `edge_sel` selects. The codes are 00 for rising, 01 for falling, and 1x for both edges. The direction comes from `dir_down`.
- R7: Quadrature mode (`mode`=11): each forward move of {pin_a,pin_b} around 00->10->11->01->00 adds one, and each backward move subtracts one. `quad_dir` shows the last step (0 forward, 1 backward). `dir_down` is ignored in this mode.
- R8: In quadrature mode a simultaneous change of both phases leaves the count unchanged and sets `quad_err`. `quad_err` then stays at 1 until reset; loads and valid moves do not clear it.
- R9: `tog_out` flips when a step carries the count from 0xFFFF to 0x0000, and when a step carries it from 0x0000 to 0xFFFF.
- R10: Without a load, the count changes by at most one in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| run | input | 1 | Counting enable; low clears the prescaler |
| mode | input | 2 | 00 timer, 01 gated, 10 event, 11 quadrature |
| dir_down | input | 1 | 1 counts down (all modes except quadrature) |
| presc_code | input | 3 | Prescale divide = 8 << code |
| gate_pol | input | 1 | Active level of the gate in gated mode |
| edge_sel | input | 2 | 00 rising, 01 falling, 1x both edges |
| load_en | input | 1 | Preload strobe |
| load_val | input | 16 | Preload value |
| pin_a | input | 1 | Gate, event input, or phase A |
| pin_b | input | 1 | Phase B |
| count | output | 16 | Current count |
| tog_out | output | 1 | Wrap toggle latch |
| quad_dir | output | 1 | Direction of the last quadrature step |
| quad_err | output | 1 | Sticky illegal-transition flag |

## Verification
The assertions check four rules on every cycle: a stopped, unloaded count holds; a load lands exactly; the count never jumps by more than one; and the error flag never clears. They also check that the toggle output changes only across a real wrap. The exact step rates depend on the prescaler code, and only the bench's scenarios can show them. The same holds for gate polarity, the edge selection, quadrature direction, and the prescaler restarting after `run` falls.

// File: rtl/mode_timer_pkg.sv
package mode_timer_pkg;
    localparam int CNT_W        = 16;
    localparam int PRE_CODE_W   = 3;
    localparam int PRE_BASE_SH  = 3;

    typedef enum logic [1:0] {
        MODE_TIMER = 2'b00,
        MODE_GATED = 2'b01,
        MODE_EVENT = 2'b10,
        MODE_QUAD  = 2'b11
    } tmode_t;

    typedef enum logic [1:0] {
        Q00 = 2'd0,
        Q10 = 2'd1,
        Q11 = 2'd2,
        Q01 = 2'd3
    } qstate_t;
endpackage

// File: rtl/mt_sync.sv
module mt_sync #(
    parameter int WIDTH = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        logic s1, s2;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                s1 <= 1'b0;
                s2 <= 1'b0;
            end else begin
                s1 <= d[i];
                s2 <= s1;
            end
        end
        assign q[i] = s2;
    end
endmodule

// File: rtl/mt_prescaler.sv
module mt_prescaler #(
    parameter int CODE_W  = 3,
    parameter int BASE_SH = 3,
    localparam int PW = BASE_SH + (1 << CODE_W) - 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic [CODE_W-1:0] code,
    output logic              tick
);
    logic [PW-1:0] pcnt;
    logic [PW:0]   divide;
    logic [PW-1:0] limit;

    always_comb begin
        divide = (PW+1)'(1) << (BASE_SH + int'(code));
        limit  = PW'(divide - (PW+1)'(1));
        tick   = run && (pcnt >= limit);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      pcnt <= '0;
        else if (!run)   pcnt <= '0;
        else if (tick)   pcnt <= '0;
        else             pcnt <= pcnt + PW'(1);
    end
endmodule

// File: rtl/mt_edge.sv
module mt_edge (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sig,
    input  logic [1:0] sel,
    output logic       event_o
);
    logic prev;
    logic rise, fall;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev <= 1'b0;
        else        prev <= sig;
    end

    always_comb begin
        rise = sig & ~prev;
        fall = ~sig & prev;
        unique case (sel)
            2'b00:   event_o = rise;
            2'b01:   event_o = fall;
            default: event_o = rise | fall;
        endcase
    end
endmodule

// File: rtl/mt_quad_dec.sv
module mt_quad_dec
    import mode_timer_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic pa,
    input  logic pb,
    output logic step,
    output logic step_down,
    output logic dir,
    output logic err
);
    qstate_t state, obs;
    logic    bad;

    always_comb begin
        unique case ({pa, pb})
            2'b00: obs = Q00;
            2'b10: obs = Q10;
            2'b11: obs = Q11;
            default: obs = Q01;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= Q00;
        else        state <= obs;
    end

    always_comb begin
        step      = 1'b0;
        step_down = 1'b0;
        bad       = 1'b0;
        unique case (state)
            Q00: unique case (obs)
                Q10: step = 1'b1;
                Q01: begin step = 1'b1; step_down = 1'b1; end
                Q11: bad = 1'b1;
                default: ;
            endcase
            Q10: unique case (obs)
                Q11: step = 1'b1;
                Q00: begin step = 1'b1; step_down = 1'b1; end
                Q01: bad = 1'b1;
                default: ;
            endcase
            Q11: unique case (obs)
                Q01: step = 1'b1;
                Q10: begin step = 1'b1; step_down = 1'b1; end
                Q00: bad = 1'b1;
                default: ;
            endcase
            default: unique case (obs)
                Q00: step = 1'b1;
                Q11: begin step = 1'b1; step_down = 1'b1; end
                Q10: bad = 1'b1;
                default: ;
            endcase
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dir <= 1'b0;
            err <= 1'b0;
        end else if (enable) begin
            if (step) dir <= step_down;
            if (bad)  err <= 1'b1;
        end
    end
endmodule

// File: rtl/mode_timer.sv
module mode_timer
    import mode_timer_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  run,
    input  logic [1:0]            mode,
    input  logic                  dir_down,
    input  logic [PRE_CODE_W-1:0] presc_code,
    input  logic                  gate_pol,
    input  logic [1:0]            edge_sel,
    input  logic                  load_en,
    input  logic [CNT_W-1:0]      load_val,
    input  logic                  pin_a,
    input  logic                  pin_b,
    output logic [CNT_W-1:0]      count,
    output logic                  tog_out,
    output logic                  quad_dir,
    output logic                  quad_err
);
    tmode_t     mode_e;
    logic [1:0] pins_s;
    logic       a_s, b_s;
    logic       tick, edge_ev, q_step, q_down;
    logic       step, down, wrap;

    assign mode_e = tmode_t'(mode);

    mt_sync #(.WIDTH(2)) u_sync (
        .clk(clk), .rst_n(rst_n), .d({pin_b, pin_a}), .q(pins_s)
    );
    assign a_s = pins_s[0];
    assign b_s = pins_s[1];

    mt_prescaler #(.CODE_W(PRE_CODE_W), .BASE_SH(PRE_BASE_SH)) u_pre (
        .clk(clk), .rst_n(rst_n), .run(run), .code(presc_code), .tick(tick)
    );

    mt_edge u_edge (
        .clk(clk), .rst_n(rst_n), .sig(a_s), .sel(edge_sel), .event_o(edge_ev)
    );

    mt_quad_dec u_quad (
        .clk(clk), .rst_n(rst_n), .enable(mode_e == MODE_QUAD),
        .pa(a_s), .pb(b_s), .step(q_step), .step_down(q_down),
        .dir(quad_dir), .err(quad_err)
    );

    always_comb begin
        unique case (mode_e)
            MODE_TIMER: begin step = tick;                        down = dir_down; end
            MODE_GATED: begin step = tick && (a_s == gate_pol);   down = dir_down; end
            MODE_EVENT: begin step = run && edge_ev;              down = dir_down; end
            default:    begin step = run && q_step;               down = q_down;   end
        endcase
        wrap = step && (down ? (count == '0) : (count == '1));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count   <= '0;
            tog_out <= 1'b0;
        end else if (load_en) begin
            count   <= load_val;
        end else if (step) begin
            count   <= down ? count - CNT_W'(1) : count + CNT_W'(1);
            tog_out <= tog_out ^ wrap;
        end
    end
endmodule

// File: rtl/mode_timer_chk.sv
module mode_timer_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        run,
    input logic        load_en,
    input logic [15:0] load_val,
    input logic [15:0] count,
    input logic        tog_out,
    input logic        quad_err
);
    assert_hold_stopped_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !load_en) |=> (count == $past(count)));

    assert_load_lands_R2: assert property (@(posedge clk) disable iff (!rst_n)
        load_en |=> (count == $past(load_val)));

    assert_single_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !load_en |=> (count == $past(count) ||
                      count == 16'($past(count) + 16'd1) ||
                      count == 16'($past(count) - 16'd1)));

    assert_toggle_on_wrap_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(tog_out) |-> (($past(count) == 16'hFFFF && count == 16'h0000) ||
                               ($past(count) == 16'h0000 && count == 16'hFFFF)));

    assert_err_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        quad_err |=> quad_err);
endmodule

bind mode_timer mode_timer_chk u_chk (
    .clk(clk), .rst_n(rst_n), .run(run), .load_en(load_en), .load_val(load_val),
    .count(count), .tog_out(tog_out), .quad_err(quad_err)
);

// File: tb/mode_timer_bench.sv
module mode_timer_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        run = 1'b0;
    logic [1:0]  mode = 2'b00;
    logic        dir_down = 1'b0;
    logic [2:0]  presc_code = 3'd0;
    logic        gate_pol = 1'b1;
    logic [1:0]  edge_sel = 2'b00;
    logic        load_en = 1'b0;
    logic [15:0] load_val = 16'h0;
    logic        pin_a = 1'b0;
    logic        pin_b = 1'b0;
    logic [15:0] count;
    logic        tog_out, quad_dir, quad_err;

    int n_checks = 0;
    int n_fail = 0;
    logic exp_tog = 1'b0;

    always #10 clk = ~clk;

    mode_timer u_mode_timer (
        .clk(clk), .rst_n(rst_n), .run(run), .mode(mode), .dir_down(dir_down),
        .presc_code(presc_code), .gate_pol(gate_pol), .edge_sel(edge_sel),
        .load_en(load_en), .load_val(load_val), .pin_a(pin_a), .pin_b(pin_b),
        .count(count), .tog_out(tog_out), .quad_dir(quad_dir), .quad_err(quad_err)
    );

    typedef struct packed {
        logic [2:0]  code;
        logic        down;
        logic [15:0] cycles;
        logic [15:0] start;
        logic [15:0] exp_cnt;
        logic        flip;
    } vec_t;

    localparam int NVEC = 6;
    localparam vec_t VECS [NVEC] = '{
        '{3'd0, 1'b0, 16'd80,   16'h0000, 16'h000A, 1'b0},
        '{3'd1, 1'b0, 16'd100,  16'h0100, 16'h0106, 1'b0},
        '{3'd2, 1'b1, 16'd64,   16'h0005, 16'h0003, 1'b0},
        '{3'd3, 1'b0, 16'd640,  16'hFFFE, 16'h0008, 1'b1},
        '{3'd5, 1'b1, 16'd1000, 16'h0001, 16'hFFFE, 1'b1},
        '{3'd7, 1'b0, 16'd2100, 16'h0000, 16'h0002, 1'b0}
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_load(input logic [15:0] v);
        load_en = 1'b1;
        load_val = v;
        tick(1);
        load_en = 1'b0;
    endtask

    task automatic pulses(input int n);
        for (int i = 0; i < n; i++) begin
            pin_a = 1'b1; tick(4);
            pin_a = 1'b0; tick(4);
        end
        tick(4);
    endtask

    task automatic phase(input logic a, input logic b);
        pin_a = a; pin_b = b; tick(4);
    endtask

    initial begin
        #(200000 * 20);
        n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        @(negedge clk); @(negedge clk);
        rst_n = 1'b1;
        tick(1);
        // R1 reset state
        check("R1 count", 32'(count), 32'h0);
        check("R1 tog", 32'(tog_out), 32'h0);
        check("R1 dir/err", 32'({quad_dir, quad_err}), 32'h0);

        // R4 / R9 table of timer-mode vectors
        for (int v = 0; v < NVEC; v++) begin
            mode = 2'b00;
            presc_code = VECS[v].code;
            dir_down = VECS[v].down;
            do_load(VECS[v].start);
            run = 1'b1;
            tick(int'(VECS[v].cycles));
            run = 1'b0;
            exp_tog = exp_tog ^ VECS[v].flip;
            check($sformatf("R4 vec%0d count", v), 32'(count), 32'(VECS[v].exp_cnt));
            check($sformatf("R9 vec%0d tog", v), 32'(tog_out), 32'(exp_tog));
        end

        // R3 hold while stopped, prescaler restart
        presc_code = 3'd0; dir_down = 1'b0;
        do_load(16'h0);
        run = 1'b1; tick(10); run = 1'b0;
        tick(20);
        check("R3 hold", 32'(count), 32'h1);
        run = 1'b1; tick(7);
        check("R3 restart early", 32'(count), 32'h1);
        tick(1);
        check("R3 restart tick", 32'(count), 32'h2);
        run = 1'b0;

        // R2 load during run overrides, then counting resumes
        do_load(16'h0);
        run = 1'b1; tick(3);
        do_load(16'h1234);
        check("R2 load", 32'(count), 32'h1234);
        tick(4);
        check("R2 after load", 32'(count), 32'h1235);
        run = 1'b0;
        check("R2 no toggle", 32'(tog_out), 32'(exp_tog));

        // R9 directed wrap both ways
        do_load(16'hFFFF);
        run = 1'b1; tick(8); run = 1'b0;
        exp_tog = ~exp_tog;
        check("R9 overflow count", 32'(count), 32'h0);
        check("R9 overflow tog", 32'(tog_out), 32'(exp_tog));
        dir_down = 1'b1;
        run = 1'b1; tick(8); run = 1'b0;
        exp_tog = ~exp_tog;
        check("R9 underflow count", 32'(count), 32'hFFFF);
        check("R9 underflow tog", 32'(tog_out), 32'(exp_tog));
        dir_down = 1'b0;

        // R5 gated mode
        mode = 2'b01; gate_pol = 1'b1; pin_a = 1'b1; tick(4);
        do_load(16'h0);
        run = 1'b1; tick(80); run = 1'b0;
        check("R5 gate open", 32'(count), 32'd10);
        pin_a = 1'b0; tick(4);
        do_load(16'h0);
        run = 1'b1; tick(80); run = 1'b0;
        check("R5 gate shut", 32'(count), 32'd0);
        gate_pol = 1'b0;
        do_load(16'h0);
        run = 1'b1; tick(80); run = 1'b0;
        check("R5 low-active gate", 32'(count), 32'd10);

        // R6 event mode
        mode = 2'b10; edge_sel = 2'b00;
        do_load(16'h0); run = 1'b1;
        pulses(5);
        check("R6 rising", 32'(count), 32'd5);
        edge_sel = 2'b01; do_load(16'h0);
        pulses(5);
        check("R6 falling", 32'(count), 32'd5);
        edge_sel = 2'b10; do_load(16'h0);
        pulses(5);
        check("R6 both", 32'(count), 32'd10);
        dir_down = 1'b1; do_load(16'd20);
        pulses(5);
        check("R6 both down", 32'(count), 32'd10);
        run = 1'b0;

        // R7 quadrature, dir_down still 1 and must be ignored
        mode = 2'b11;
        do_load(16'd100); run = 1'b1;
        for (int k = 0; k < 2; k++) begin
            phase(1, 0); phase(1, 1); phase(0, 1); phase(0, 0);
        end
        tick(4);
        check("R7 forward count", 32'(count), 32'd108);
        check("R7 forward dir", 32'(quad_dir), 32'd0);
        phase(0, 1); phase(1, 1); phase(1, 0); phase(0, 0);
        tick(4);
        check("R7 backward count", 32'(count), 32'd104);
        check("R7 backward dir", 32'(quad_dir), 32'd1);
        check("R8 no err yet", 32'(quad_err), 32'd0);

        // R8 illegal double change
        pin_a = 1'b1; pin_b = 1'b1; tick(6);
        check("R8 ignored", 32'(count), 32'd104);
        check("R8 err set", 32'(quad_err), 32'd1);
        phase(0, 1); tick(4);
        check("R8 resume", 32'(count), 32'd105);
        check("R8 sticky", 32'(quad_err), 32'd1);
        run = 1'b0;
        do_load(16'h0);
        check("R8 sticky after load", 32'(quad_err), 32'd1);

        // R1 reset clears everything
        rst_n = 1'b0; tick(2); rst_n = 1'b1; tick(1);
        check("R1 re-reset count", 32'(count), 32'h0);
        check("R1 re-reset flags", 32'({tog_out, quad_err}), 32'h0);

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule